// File: doc/BRIEF.md
# Width-Selectable Read-Modify-Write Bit Unit

This unit carries out the bit and shift group of a CPU with a 16-bit accumulator. That group covers test-and-set bits, test-and-reset bits, bit test, arithmetic shift left, logical shift right, rotate left and rotate right. A single width input picks 8-bit or 16-bit operation. Each operand comes from one of three places: the accumulator, an immediate value, or memory. A memory operand moves over a byte-wide request/ready channel, low byte first. The unit returns the new N, V, Z and C flags, the new accumulator value, and a count of the extra cycles the instruction costs.

The surrounding CPU already holds the effective address, the accumulator and the current flags. It presents them together with a one-cycle `start` pulse, and the unit captures all of them on that edge. The memory channel works as a valid/ready stream. `mem_req` is the valid signal. Address, direction and write data stay frozen until the memory raises `mem_ready`, and a byte moves on every clock edge where both are high. The memory may hold `mem_ready` low for any number of cycles.

Top module: `rmw_bit_unit`

## Requirements
- R1: With `narrow`=0 (16-bit), a memory operand is read from `base_addr` and then from `base_addr`+1, with the increment wrapping modulo 2^24. A read-modify-write operation then writes back to the same two addresses, low byte first.
- R2: With `narrow`=1, a memory operation makes exactly one read and, unless it is bit test, exactly one write. Both go to `base_addr` only.
- R3: Test-and-set (`op_sel`=0) writes operand OR accumulator. Z is set when that written value is zero over the active width.
- R4: Test-and-reset (`op_sel`=1) writes operand AND NOT accumulator. Z comes from operand AND accumulator, taken before the bits are cleared.
- R5: Bit test (`op_sel`=2) never writes. Z = (operand AND accumulator)==0. N takes the operand's bit 7 or bit 15, and V takes the bit just below it. In immediate mode (`amode`=1), N and V keep their inputs and the bus stays idle.
- R6: Shift left (`op_sel`=3) and rotate left (`op_sel`=5) move the top bit of the active width into C. Rotate left puts the old C into bit 0. N is the top bit of the result.
- R7: Logical shift right (`op_sel`=4) and rotate right (`op_sel`=6) move bit 0 into C and always clear N. Rotate right puts the old C into bit 7 when narrow, or into bit 15 when wide.
- R8: In accumulator mode (`amode`=0), shifts use no bus cycles and report zero extra cycles. When narrow, only the accumulator's low byte changes and Z and N look at that byte alone.
- R9: `extra_cyc` is the sum of three terms. The width term is 2 for a wide memory read-modify-write, 1 for a wide bit test, and 0 otherwise. The direct-page term is 1 when `dp_low_nz` is set and `amode` is 2 (direct), or `amode` is 3 (direct indexed) for bit test and the shifts. The page term is 1 when `page_crossed` is set and `amode`=4 (absolute indexed) for bit test and the shifts. Any other `amode` value adds nothing.
- R10: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable while `mem_ready` is low. `busy` is high from the cycle after `start` until the operation completes. `done` is a one-cycle pulse raised the cycle `busy` drops. Flags, `acc_out` and `extra_cyc` are valid from `done` and held until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin operation (only while idle) |
| op_sel | input | 3 | Operation code 0..6 |
| amode | input | 3 | 0 acc, 1 immediate, 2 direct, 3 direct indexed, 4 absolute indexed, 5 other |
| narrow | input | 1 | 1 = 8-bit, 0 = 16-bit |
| base_addr | input | 24 | Operand address |
| acc_in | input | 16 | Accumulator |
| imm_in | input | 16 | Immediate operand |
| c_in | input | 1 | Current C |
| n_in | input | 1 | Current N |
| v_in | input | 1 | Current V |
| dp_low_nz | input | 1 | Direct-page register low byte is nonzero |
| page_crossed | input | 1 | Indexing crossed a page |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| acc_out | output | 16 | Resulting accumulator |
| n_out | output | 1 | N flag |
| v_out | output | 1 | V flag |
| z_out | output | 1 | Z flag |
| c_out | output | 1 | C flag |
| extra_cyc | output | 2 | Extra cycle count |
| mem_req | output | 1 | Byte transfer valid |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |
| mem_ready | input | 1 | Transfer accepted |

## Verification
The assertions rely on four things about the inputs. `start` arrives only while `busy` is low. `mem_ready` may stall but eventually rises, and `mem_rdata` is valid on the accepting edge. The operation and addressing-mode pairs are legal: test-and-set and test-and-reset always use memory, bit test never uses accumulator mode, and shifts never use immediate mode. The bench keeps to these rules in every task. Each task waits for `done` before issuing the next `start`, runs the bus with an alternating stall pattern during part of the tests, and drives only those legal pairs.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    OP_TSET = 3'd0, OP_TCLR = 3'd1, OP_BTST = 3'd2, OP_SHL = 3'd3,
    OP_SHR  = 3'd4, OP_RTL  = 3'd5, OP_RTR  = 3'd6, OP_NONE = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    AM_ACC = 3'd0, AM_IMM = 3'd1, AM_DIR = 3'd2, AM_DIRX = 3'd3,
    AM_ABSX = 3'd4, AM_OTHER = 3'd5, AM_R6 = 3'd6, AM_R7 = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_WR0, ST_WR1, ST_EXEC
  } state_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  op_e               op,
  input  logic              narrow,
  input  logic              is_imm,
  input  logic [WORD_W-1:0] opnd,
  input  logic [WORD_W-1:0] acc,
  input  logic              cin,
  input  logic              nin,
  input  logic              vin,
  output logic [WORD_W-1:0] res,
  output flags_t            fl
);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] mask;
  logic              top_bit;
  logic              sub_bit;

  always_comb begin
    mask    = narrow ? {{HALF{1'b0}}, {HALF{1'b1}}} : {WORD_W{1'b1}};
    top_bit = narrow ? opnd[HALF-1] : opnd[WORD_W-1];
    sub_bit = narrow ? opnd[HALF-2] : opnd[WORD_W-2];
    res     = opnd;
    fl      = '{n: nin, v: vin, z: 1'b0, c: cin};
    unique case (op)
      OP_TSET: begin
        res  = opnd | acc;
        fl.z = ((opnd | acc) & mask) == '0;
      end
      OP_TCLR: begin
        res  = opnd & ~acc;
        fl.z = ((opnd & acc) & mask) == '0;
      end
      OP_BTST: begin
        fl.z = ((opnd & acc) & mask) == '0;
        if (!is_imm) begin
          fl.n = top_bit;
          fl.v = sub_bit;
        end
      end
      OP_SHL, OP_RTL: begin
        if (narrow)
          res = {opnd[WORD_W-1:HALF], opnd[HALF-2:0], (op == OP_RTL) & cin};
        else
          res = {opnd[WORD_W-2:0], (op == OP_RTL) & cin};
        fl.c = top_bit;
        fl.n = narrow ? res[HALF-1] : res[WORD_W-1];
        fl.z = (res & mask) == '0;
      end
      OP_SHR, OP_RTR: begin
        if (narrow)
          res = {opnd[WORD_W-1:HALF], (op == OP_RTR) & cin, opnd[HALF-1:1]};
        else
          res = {(op == OP_RTR) & cin, opnd[WORD_W-1:1]};
        fl.c = opnd[0];
        fl.n = 1'b0;
        fl.z = (res & mask) == '0;
      end
      default: fl.z = (opnd & mask) == '0;
    endcase
  end
endmodule

// File: rtl/rmw_penalty.sv
module rmw_penalty
  import rmw_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  op_e              op,
  input  amode_e           mode,
  input  logic             narrow,
  input  logic             dp_nz,
  input  logic             pg_cross,
  output logic [CNT_W-1:0] extra
);
  logic             tst_family;
  logic [CNT_W-1:0] width_term;
  logic             dp_term;
  logic             pg_term;

  always_comb begin
    tst_family = (op == OP_TSET) || (op == OP_TCLR);
    if (narrow)             width_term = '0;
    else if (op == OP_BTST) width_term = CNT_W'(1);
    else                    width_term = CNT_W'(2);
    dp_term = dp_nz && ((mode == AM_DIR) || (mode == AM_DIRX && !tst_family));
    pg_term = pg_cross && (mode == AM_ABSX) && !tst_family;
    if (mode == AM_ACC)
      extra = '0;
    else
      extra = width_term + CNT_W'(dp_term) + CNT_W'(pg_term);
  end
endmodule

// File: rtl/rmw_bus_port.sv
module rmw_bus_port
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  state_e            state,
  input  logic [ADDR_W-1:0] base,
  input  logic [WORD_W-1:0] wr_word,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata
);
  logic hi_byte;

  always_comb begin
    hi_byte = (state == ST_RD1) || (state == ST_WR1);
    req     = (state == ST_RD0) || (state == ST_RD1) ||
              (state == ST_WR0) || (state == ST_WR1);
    we      = (state == ST_WR0) || (state == ST_WR1);
    addr    = hi_byte ? base + ADDR_W'(1) : base;
    wdata   = hi_byte ? wr_word[15:8] : wr_word[7:0];
  end
endmodule

// File: rtl/rmw_bit_unit.sv
module rmw_bit_unit
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic [2:0]        amode,
  input  logic              narrow,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] imm_in,
  input  logic              c_in,
  input  logic              n_in,
  input  logic              v_in,
  input  logic              dp_low_nz,
  input  logic              page_crossed,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] acc_out,
  output logic              n_out,
  output logic              v_out,
  output logic              z_out,
  output logic              c_out,
  output logic [CNT_W-1:0]  extra_cyc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready
);
  localparam int HALF = WORD_W / 2;

  state_e            state_q;
  op_e               op_q;
  amode_e            mode_q;
  logic              narrow_q, cin_q, nin_q, vin_q, dpnz_q, pgx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] acc_q, opnd_q;
  logic [WORD_W-1:0] alu_res;
  flags_t            alu_fl, fl_q;
  logic [CNT_W-1:0]  pen;
  logic              xfer, finish, on_bus, is_shift;

  rmw_alu #(.WORD_W(WORD_W)) alu_i (
    .op(op_q), .narrow(narrow_q), .is_imm(mode_q == AM_IMM), .opnd(opnd_q),
    .acc(acc_q), .cin(cin_q), .nin(nin_q), .vin(vin_q), .res(alu_res), .fl(alu_fl)
  );

  rmw_penalty #(.CNT_W(CNT_W)) pen_i (
    .op(op_q), .mode(mode_q), .narrow(narrow_q), .dp_nz(dpnz_q),
    .pg_cross(pgx_q), .extra(pen)
  );

  rmw_bus_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) port_i (
    .state(state_q), .base(addr_q), .wr_word(alu_res), .req(mem_req),
    .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
  );

  assign xfer     = mem_req && mem_ready;
  assign on_bus   = (amode != AM_ACC) && (amode != AM_IMM);
  assign is_shift = (op_q == OP_SHL) || (op_q == OP_SHR) ||
                    (op_q == OP_RTL) || (op_q == OP_RTR);
  assign finish   = (state_q == ST_EXEC) ||
                    (state_q == ST_WR0 && xfer && narrow_q) ||
                    (state_q == ST_WR1 && xfer);
  assign busy     = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_NONE;
      mode_q   <= AM_ACC;
      narrow_q <= 1'b0;
      cin_q    <= 1'b0;
      nin_q    <= 1'b0;
      vin_q    <= 1'b0;
      dpnz_q   <= 1'b0;
      pgx_q    <= 1'b0;
      addr_q   <= '0;
      acc_q    <= '0;
      opnd_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          op_q     <= op_e'(op_sel);
          mode_q   <= amode_e'(amode);
          narrow_q <= narrow;
          cin_q    <= c_in;
          nin_q    <= n_in;
          vin_q    <= v_in;
          dpnz_q   <= dp_low_nz;
          pgx_q    <= page_crossed;
          addr_q   <= base_addr;
          acc_q    <= acc_in;
          if (on_bus)                 opnd_q <= '0;
          else if (amode == AM_ACC)   opnd_q <= acc_in;
          else                        opnd_q <= imm_in;
          state_q  <= on_bus ? ST_RD0 : ST_EXEC;
        end
        ST_RD0: if (xfer) begin
          opnd_q[HALF-1:0] <= mem_rdata;
          if (!narrow_q)             state_q <= ST_RD1;
          else if (op_q == OP_BTST)  state_q <= ST_EXEC;
          else                       state_q <= ST_WR0;
        end
        ST_RD1: if (xfer) begin
          opnd_q[WORD_W-1:HALF] <= mem_rdata;
          state_q <= (op_q == OP_BTST) ? ST_EXEC : ST_WR0;
        end
        ST_WR0: if (xfer) state_q <= narrow_q ? ST_IDLE : ST_WR1;
        ST_WR1: if (xfer) state_q <= ST_IDLE;
        ST_EXEC: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      fl_q      <= '0;
      acc_out   <= '0;
      extra_cyc <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        fl_q      <= alu_fl;
        extra_cyc <= pen;
        acc_out   <= (is_shift && mode_q == AM_ACC) ? alu_res : acc_q;
      end
    end
  end

  assign n_out = fl_q.n;
  assign v_out = fl_q.v;
  assign z_out = fl_q.z;
  assign c_out = fl_q.c;
endmodule

// File: rtl/rmw_bit_unit_chk.sv
module rmw_bit_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        n_out,
  input logic [1:0]  extra_cyc,
  input logic        mem_req,
  input logic        mem_we,
  input logic [23:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_ready,
  input logic        narrow_q,
  input logic [23:0] addr_q,
  input logic [2:0]  op_q,
  input logic [2:0]  mode_q
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_narrow_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && narrow_q |-> mem_addr == addr_q);

  p_btst_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && op_q == 3'd2 |-> !mem_we);

  p_rshift_n_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && (op_q == 3'd4 || op_q == 3'd6) |-> !n_out);

  p_acc_mode_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 3'd0 |-> extra_cyc == 2'd0);
endmodule

bind rmw_bit_unit rmw_bit_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .n_out(n_out),
  .extra_cyc(extra_cyc), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .narrow_q(narrow_q),
  .addr_q(addr_q), .op_q(op_q), .mode_q(mode_q)
);

// File: tb/rmw_bit_unit_tb_top.sv
`timescale 1ns/1ps
module rmw_bit_unit_tb_top;
  localparam logic [2:0] TSET = 3'd0, TCLR = 3'd1, BTST = 3'd2, SHL = 3'd3,
                         SHR = 3'd4, RTL = 3'd5, RTR = 3'd6;
  localparam logic [2:0] M_ACC = 3'd0, M_IMM = 3'd1, M_DIR = 3'd2,
                         M_DIRX = 3'd3, M_ABSX = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op_sel = '0, amode = '0;
  logic narrow = 1'b0, c_in = 1'b0, n_in = 1'b0, v_in = 1'b0;
  logic dp_low_nz = 1'b0, page_crossed = 1'b0;
  logic [23:0] base_addr = '0;
  logic [15:0] acc_in = '0, imm_in = '0;
  logic busy, done, n_out, v_out, z_out, c_out, mem_req, mem_we, mem_ready;
  logic [15:0] acc_out;
  logic [1:0] extra_cyc;
  logic [23:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  rmw_bit_unit dut_i (.*);

  logic [7:0] mem [256];
  logic stall_en = 1'b0, clr_log = 1'b0, pl_en = 1'b0;
  logic [7:0] pl_addr = '0, pl_data = '0;
  logic [1:0] stall_cnt = '0;
  logic lg_we [8];
  logic [23:0] lg_addr [8];
  int n_acc = 0;
  int total = 0, bad = 0;

  assign mem_ready = !stall_en || stall_cnt[0];
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 2'd1;
    if (pl_en) mem[pl_addr] <= pl_data;
    if (clr_log) n_acc <= 0;
    else if (mem_req && mem_ready) begin
      if (n_acc < 8) begin
        lg_we[n_acc]   <= mem_we;
        lg_addr[n_acc] <= mem_addr;
      end
      n_acc <= n_acc + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic run(input logic [2:0] op, input logic [2:0] md, input logic nar,
                     input logic [23:0] a, input logic [15:0] acc, input logic [15:0] imm,
                     input logic ci, input logic ni, input logic vi,
                     input logic dpnz, input logic pc);
    int guard;
    logic [15:0] acc_seen;
    @(negedge clk);
    op_sel = op; amode = md; narrow = nar; base_addr = a; acc_in = acc; imm_in = imm;
    c_in = ci; n_in = ni; v_in = vi; dp_low_nz = dpnz; page_crossed = pc;
    start = 1'b1; clr_log = 1'b1;
    @(negedge clk);
    start = 1'b0; clr_log = 1'b0;
    chk("R10 busy after start", busy, 1);
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk("R10 done reached", done, 1);
    chk("R10 busy low at done", busy, 0);
    acc_seen = acc_out;
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    chk("R10 acc_out held", acc_out, acc_seen);
  endtask

  task automatic t_reset;
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset req", mem_req, 0);
  endtask

  task automatic t_tset;
    stall_en = 1'b1;
    poke(8'h10, 8'h34); poke(8'h11, 8'h12);
    run(TSET, M_DIR, 1'b0, 24'h000010, 16'h0F00, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 low byte", mem[8'h10], 8'h34);
    chk("R3 high byte", mem[8'h11], 8'h1F);
    chk("R3 z", z_out, 0);
    chk("R3 c kept", c_out, 1);
    chk("R1 access count", n_acc, 4);
    chk("R1 rd0", {lg_we[0], lg_addr[0]}, {1'b0, 24'h000010});
    chk("R1 rd1", {lg_we[1], lg_addr[1]}, {1'b0, 24'h000011});
    chk("R1 wr0", {lg_we[2], lg_addr[2]}, {1'b1, 24'h000010});
    chk("R1 wr1", {lg_we[3], lg_addr[3]}, {1'b1, 24'h000011});
    chk("R9 wide rmw + dp", extra_cyc, 3);
    chk("R10 acc_out passthrough", acc_out, 16'h0F00);
    poke(8'h20, 8'h00); poke(8'h21, 8'h55);
    run(TSET, M_DIR, 1'b1, 24'h000020, 16'h7700, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 narrow zero z", z_out, 1);
    chk("R2 narrow count", n_acc, 2);
    chk("R2 narrow wr addr", {lg_we[1], lg_addr[1]}, {1'b1, 24'h000020});
    chk("R2 neighbour untouched", mem[8'h21], 8'h55);
    chk("R9 narrow dp clear", extra_cyc, 0);
    stall_en = 1'b0;
  endtask

  task automatic t_tclr;
    poke(8'h30, 8'hF0); poke(8'h31, 8'hF0);
    run(TCLR, M_DIRX, 1'b0, 24'h000030, 16'h0F0F, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 low", mem[8'h30], 8'hF0);
    chk("R4 high", mem[8'h31], 8'hF0);
    chk("R4 z from and", z_out, 1);
    chk("R9 tclr no dp on indexed", extra_cyc, 2);
    poke(8'h40, 8'hFF);
    run(TCLR, M_ABSX, 1'b1, 24'h000040, 16'h0011, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 narrow cleared", mem[8'h40], 8'hEE);
    chk("R4 narrow z", z_out, 0);
    chk("R9 tclr no page term", extra_cyc, 0);
  endtask

  task automatic t_btst;
    stall_en = 1'b1;
    poke(8'h50, 8'h01); poke(8'h51, 8'hC0);
    run(BTST, M_DIRX, 1'b0, 24'h000050, 16'h0001, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 z", z_out, 0);
    chk("R5 n", n_out, 1);
    chk("R5 v", v_out, 1);
    chk("R5 reads only", n_acc, 2);
    chk("R5 no write", lg_we[0] | lg_we[1], 0);
    chk("R5 mem kept", mem[8'h51], 8'hC0);
    chk("R9 btst wide + dp indexed", extra_cyc, 2);
    stall_en = 1'b0;
    run(BTST, M_IMM, 1'b1, 24'h0, 16'h0001, 16'h00C0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 imm z", z_out, 1);
    chk("R5 imm n kept", n_out, 0);
    chk("R5 imm v kept", v_out, 1);
    chk("R5 imm no bus", n_acc, 0);
    chk("R9 imm narrow", extra_cyc, 0);
    run(BTST, M_IMM, 1'b0, 24'h0, 16'h4000, 16'h4000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 wide imm z", z_out, 0);
    chk("R5 wide imm n kept", n_out, 1);
    chk("R9 wide btst", extra_cyc, 1);
  endtask

  task automatic t_mem_shifts;
    poke(8'h60, 8'h81); poke(8'h61, 8'h99);
    run(SHL, M_ABSX, 1'b1, 24'h000060, 16'h0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R6 shl result", mem[8'h60], 8'h02);
    chk("R6 shl c", c_out, 1);
    chk("R6 shl n", n_out, 0);
    chk("R2 shl high untouched", mem[8'h61], 8'h99);
    chk("R9 page term", extra_cyc, 1);
    poke(8'hFF, 8'h00); poke(8'h00, 8'h80);
    stall_en = 1'b1;
    run(RTL, M_ABSX, 1'b0, 24'hFFFFFF, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    stall_en = 1'b0;
    chk("R6 rtl low", mem[8'hFF], 8'h01);
    chk("R6 rtl high", mem[8'h00], 8'h00);
    chk("R6 rtl c", c_out, 1);
    chk("R1 wrap rd1", lg_addr[1], 24'h000000);
    chk("R1 wrap wr0", lg_addr[2], 24'hFFFFFF);
    chk("R9 wide rmw + page", extra_cyc, 3);
    poke(8'h70, 8'h01);
    run(RTR, M_DIR, 1'b1, 24'h000070, 16'h0, 16'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 rtr narrow", mem[8'h70], 8'h80);
    chk("R7 rtr c", c_out, 1);
    chk("R7 rtr n low", n_out, 0);
    chk("R9 narrow dp", extra_cyc, 1);
  endtask

  task automatic t_acc_shifts;
    run(SHR, M_ACC, 1'b1, 24'h0, 16'hAB01, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R8 shr narrow acc", acc_out, 16'hAB00);
    chk("R8 shr z low byte", z_out, 1);
    chk("R7 shr c", c_out, 1);
    chk("R7 shr n", n_out, 0);
    chk("R8 no bus", n_acc, 0);
    chk("R8 no extra", extra_cyc, 0);
    run(RTR, M_ACC, 1'b0, 24'h0, 16'h0002, 16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 rtr wide acc", acc_out, 16'h8001);
    chk("R7 rtr wide n forced", n_out, 0);
    chk("R7 rtr wide c", c_out, 0);
    run(SHL, M_ACC, 1'b0, 24'h0, 16'h4000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 shl wide acc", acc_out, 16'h8000);
    chk("R6 shl wide n", n_out, 1);
    run(RTL, M_ACC, 1'b1, 24'h0, 16'h1280, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 rtl narrow keeps high", acc_out, 16'h1200);
    chk("R6 rtl narrow c", c_out, 1);
    chk("R8 rtl narrow z", z_out, 1);
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_tset;
    t_tclr;
    t_btst;
    t_mem_shifts;
    t_acc_shifts;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule